// File: doc/BRIEF.md
# Message-Signalled Interrupt Termination Bank

This block is the landing zone for message-signalled interrupts. An endpoint raises an interrupt by writing a small number to an address. The address picks one of 16 groups and one of 8 pending registers inside that group. The number written picks which of the 16 bits in that register gets set. Pending bits build up until software reads the register. That read returns the bits and clears them in the same access.

Each group has a read-only summary word, with one bit per pending register that holds anything. Each group also has a level interrupt output, which stays high while its summary is nonzero. A service routine reads a summary, walks the flagged registers, and re-reads the summary until it is empty. At that point the group's interrupt line drops.

Top module: `msi_term_bank`

## Requirements
- R1: Pending register x of group g answers at byte offset g*2^19 + x*2^16. The low 16 address bits must be zero; any other low value decodes to nothing.
- R2: A write of value d, with d from 0 to 15, to a pending register sets bit d of that register. No other bit and no other register changes.
- R3: The summary word of group g answers at offset 0x800000 + g*2^16. Its bit x is 1 exactly when pending register x of that group is nonzero. Bits above 7 read as zero, and reading the summary changes nothing.
- R4: A read of a pending register returns its contents on `rd_data` one cycle after `rd_valid`, and clears the register at that same clock edge.
- R5: `irq_out[g]` is high while the summary of group g is nonzero. It rises in the cycle after a write that sets a bit in that group, and falls once every flagged register of the group has been read.
- R6: A write is ignored when its value is 16 or more, or when its address decodes to no pending register (this includes summary offsets). Such a write pulses `wr_err` high for exactly the one cycle after it.
- R7: When a write and a read hit the same pending register in the same cycle, the read returns the old contents. The newly written bit is set afterwards.
- R8: Reset clears every pending register, so all summaries and all interrupt outputs are low after reset.
- R9: A read of an offset that decodes to nothing returns zero and changes no pending state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_valid | input | 1 | Message write strobe |
| wr_addr | input | 24 | Message write byte offset |
| wr_data | input | 32 | Message write value (bit number) |
| wr_err | output | 1 | One-cycle pulse for a rejected write |
| rd_valid | input | 1 | Register read strobe |
| rd_addr | input | 24 | Register read byte offset |
| rd_data | output | 16 | Read result, valid the cycle after `rd_valid` |
| irq_out | output | 16 | Per-group level interrupt |

## Verification
A pending bit lands at the clock edge that samples the write. The summary and `irq_out` follow that state combinationally, so they are due one cycle after the write. Read data and the clear both come from the edge that samples `rd_valid`, so the returned value is due one cycle after the request. A rejected write shows on `wr_err` for exactly the following cycle.

The bench drives inputs on the falling edge and samples every result on the next falling edge. This lands each check half a cycle after the register it depends on has updated. The bench then samples once more to confirm that `wr_err` has dropped again.

// File: rtl/msi_bank_pkg.sv
package msi_bank_pkg;
  typedef enum logic [1:0] {
    HIT_NONE    = 2'd0,
    HIT_PENDING = 2'd1,
    HIT_SUMMARY = 2'd2
  } hit_kind_e;

  // Width needed to hold a value in 0..n-1 (at least one bit).
  function automatic int idx_width(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/msi_addr_decode.sv
module msi_addr_decode
  import msi_bank_pkg::*;
#(
  parameter int ADDR_W     = 24,
  parameter int NUM_GROUPS = 16,
  parameter int NUM_IDX    = 8,
  parameter int REG_SHIFT  = 16,
  localparam int GRP_W     = idx_width(NUM_GROUPS),
  localparam int IDX_W     = idx_width(NUM_IDX)
) (
  input  logic [ADDR_W-1:0] addr,
  output hit_kind_e         kind,
  output logic [GRP_W-1:0]  grp,
  output logic [IDX_W-1:0]  idx
);
  // Pending region: group field above index field, summary flag on top.
  localparam int GRP_SHIFT = REG_SHIFT + IDX_W;
  localparam int SUM_BIT   = GRP_SHIFT + GRP_W;
  localparam int SUM_GAP   = SUM_BIT - (REG_SHIFT + GRP_W);

  logic low_clear;
  logic pend_hit;
  logic sum_hit;

  always_comb begin
    low_clear = (addr[REG_SHIFT-1:0] == '0);
    pend_hit  = low_clear && ((addr >> SUM_BIT) == '0);
    sum_hit   = low_clear &&
                ((addr >> (REG_SHIFT + GRP_W)) == (ADDR_W'(1) << SUM_GAP));
    kind = HIT_NONE;
    grp  = '0;
    idx  = '0;
    if (pend_hit) begin
      kind = HIT_PENDING;
      grp  = addr[GRP_SHIFT +: GRP_W];
      idx  = addr[REG_SHIFT +: IDX_W];
    end else if (sum_hit) begin
      kind = HIT_SUMMARY;
      grp  = addr[REG_SHIFT +: GRP_W];
    end
  end
endmodule

// File: rtl/msi_group.sv
module msi_group
  import msi_bank_pkg::*;
#(
  parameter int NUM_IDX  = 8,
  parameter int VEC_BITS = 16,
  localparam int IDX_W   = idx_width(NUM_IDX),
  localparam int VEC_W   = idx_width(VEC_BITS)
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic                               set_en,
  input  logic [IDX_W-1:0]                   set_idx,
  input  logic [VEC_W-1:0]                   set_bit,
  input  logic                               clr_en,
  input  logic [IDX_W-1:0]                   clr_idx,
  output logic [NUM_IDX-1:0][VEC_BITS-1:0]   vec_q,
  output logic [NUM_IDX-1:0]                 summary,
  output logic                               irq
);
  logic [NUM_IDX-1:0][VEC_BITS-1:0] set_mask;
  logic [NUM_IDX-1:0]               clr_hit;

  for (genvar x = 0; x < NUM_IDX; x++) begin : g_reg
    always_comb begin
      set_mask[x] = '0;
      if (set_en && set_idx == IDX_W'(x)) set_mask[x][set_bit] = 1'b1;
      clr_hit[x] = clr_en && (clr_idx == IDX_W'(x));
    end

    // Clear first, then OR in the new bit so a same-cycle write survives.
    always_ff @(posedge clk) begin
      if (!rst_n) vec_q[x] <= '0;
      else        vec_q[x] <= (clr_hit[x] ? '0 : vec_q[x]) | set_mask[x];
    end

    assign summary[x] = |vec_q[x];

    assert_set_lands_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (set_mask[x] != '0) |=> ((vec_q[x] & $past(set_mask[x])) == $past(set_mask[x])));

    assert_read_clears_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_hit[x] && set_mask[x] == '0) |=> (vec_q[x] == '0));

    assert_keep_new_bit_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_hit[x] && set_mask[x] != '0) |=> (vec_q[x] == $past(set_mask[x])));
  end

  assign irq = |summary;

  assert_irq_follows_set_R5: assert property (@(posedge clk) disable iff (!rst_n)
    set_en |=> irq);
endmodule

// File: rtl/msi_term_bank.sv
module msi_term_bank
  import msi_bank_pkg::*;
#(
  parameter int ADDR_W     = 24,
  parameter int DATA_W     = 32,
  parameter int NUM_GROUPS = 16,
  parameter int NUM_IDX    = 8,
  parameter int VEC_BITS   = 16,
  parameter int REG_SHIFT  = 16
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_valid,
  input  logic [ADDR_W-1:0]     wr_addr,
  input  logic [DATA_W-1:0]     wr_data,
  output logic                  wr_err,
  input  logic                  rd_valid,
  input  logic [ADDR_W-1:0]     rd_addr,
  output logic [VEC_BITS-1:0]   rd_data,
  output logic [NUM_GROUPS-1:0] irq_out
);
  localparam int GRP_W = idx_width(NUM_GROUPS);
  localparam int IDX_W = idx_width(NUM_IDX);
  localparam int VEC_W = idx_width(VEC_BITS);

  hit_kind_e        wr_kind, rd_kind;
  logic [GRP_W-1:0] wr_grp, rd_grp;
  logic [IDX_W-1:0] wr_idx, rd_idx;

  msi_addr_decode #(.ADDR_W(ADDR_W), .NUM_GROUPS(NUM_GROUPS), .NUM_IDX(NUM_IDX),
                    .REG_SHIFT(REG_SHIFT)) u_wr_dec (
    .addr(wr_addr), .kind(wr_kind), .grp(wr_grp), .idx(wr_idx));

  msi_addr_decode #(.ADDR_W(ADDR_W), .NUM_GROUPS(NUM_GROUPS), .NUM_IDX(NUM_IDX),
                    .REG_SHIFT(REG_SHIFT)) u_rd_dec (
    .addr(rd_addr), .kind(rd_kind), .grp(rd_grp), .idx(rd_idx));

  // Named events for the assertions.
  logic wr_accept, wr_reject, rd_pend, rd_none;
  assign wr_accept = wr_valid && (wr_kind == HIT_PENDING) && (wr_data < DATA_W'(VEC_BITS));
  assign wr_reject = wr_valid && !wr_accept;
  assign rd_pend   = rd_valid && (rd_kind == HIT_PENDING);
  assign rd_none   = rd_valid && (rd_kind == HIT_NONE);

  logic [NUM_GROUPS-1:0][NUM_IDX-1:0][VEC_BITS-1:0] bank;
  logic [NUM_GROUPS-1:0][NUM_IDX-1:0]               sums;

  for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_grp
    msi_group #(.NUM_IDX(NUM_IDX), .VEC_BITS(VEC_BITS)) u_group (
      .clk     (clk),
      .rst_n   (rst_n),
      .set_en  (wr_accept && wr_grp == GRP_W'(g)),
      .set_idx (wr_idx),
      .set_bit (wr_data[VEC_W-1:0]),
      .clr_en  (rd_pend && rd_grp == GRP_W'(g)),
      .clr_idx (rd_idx),
      .vec_q   (bank[g]),
      .summary (sums[g]),
      .irq     (irq_out[g])
    );
  end

  logic [VEC_BITS-1:0] rd_next;
  always_comb begin
    case (rd_kind)
      HIT_PENDING: rd_next = bank[rd_grp][rd_idx];
      HIT_SUMMARY: rd_next = VEC_BITS'(sums[rd_grp]);
      default:     rd_next = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_data <= '0;
      wr_err  <= 1'b0;
    end else begin
      if (rd_valid) rd_data <= rd_next;
      wr_err <= wr_reject;
    end
  end

  assert_reject_flags_R6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_reject |=> wr_err);

  assert_err_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_reject |=> !wr_err);

  assert_reject_no_effect_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_reject && !rd_valid) |=> $stable(irq_out));

  assert_undecoded_read_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_none && !wr_valid) |=> (rd_data == '0 && $stable(irq_out)));
endmodule

// File: tb/msi_term_bank_test.sv
module msi_term_bank_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_valid;
  logic [23:0] wr_addr;
  logic [31:0] wr_data;
  logic        wr_err;
  logic        rd_valid;
  logic [23:0] rd_addr;
  logic [15:0] rd_data;
  logic [15:0] irq_out;

  msi_term_bank uut (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0;
  int fails  = 0;
  logic [15:0] expv [16][8];

  function automatic logic [23:0] pend_off(int g, int x);
    return 24'(g * 524288 + x * 65536);
  endfunction

  function automatic logic [23:0] sum_off(int g);
    return 24'(8388608 + g * 65536);
  endfunction

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_write(input logic [23:0] a, input logic [31:0] d);
    wr_valid = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_valid = 1'b0;
  endtask

  task automatic do_read(input logic [23:0] a, output logic [15:0] v);
    rd_valid = 1'b1; rd_addr = a;
    @(negedge clk);
    rd_valid = 1'b0;
    v = rd_data;
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog actual=0 expected=1");
    finish_run();
  end

  initial begin
    logic [15:0] v;
    logic [15:0] sumexp;
    rst_n = 1'b0; wr_valid = 1'b0; rd_valid = 1'b0;
    wr_addr = '0; wr_data = '0; rd_addr = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R8: reset state
    chk(irq_out == 16'h0, "R8 irq after reset", irq_out, 0);
    for (int g = 0; g < 16; g++) begin
      do_read(sum_off(g), v);
      chk(v == 16'h0, "R8 summary after reset", v, 0);
    end

    // R1/R2/R5: sweep every register with two computed bits
    for (int g = 0; g < 16; g++)
      for (int x = 0; x < 8; x++) begin
        expv[g][x] = '0;
        expv[g][x][(g * 3 + x) % 16] = 1'b1;
        expv[g][x][(x * 5 + 1) % 16] = 1'b1;
        do_write(pend_off(g, x), 32'((g * 3 + x) % 16));
        chk(irq_out[g] == 1'b1, "R5 irq rises after write", irq_out[g], 1);
        chk(wr_err == 1'b0, "R2 no error on good write", wr_err, 0);
        do_write(pend_off(g, x), 32'((x * 5 + 1) % 16));
      end
    chk(irq_out == 16'hFFFF, "R5 all groups pending", irq_out, 16'hFFFF);

    // R3: summaries, read twice to show no side effect
    for (int g = 0; g < 16; g++) begin
      do_read(sum_off(g), v);
      chk(v == 16'h00FF, "R3 summary full", v, 16'h00FF);
      do_read(sum_off(g), v);
      chk(v == 16'h00FF, "R3 summary read unchanged", v, 16'h00FF);
    end

    // R4/R3/R5: drain each group, summary shrinks as it goes
    for (int g = 0; g < 16; g++) begin
      sumexp = 16'h00FF;
      for (int x = 0; x < 8; x++) begin
        do_read(pend_off(g, x), v);
        chk(v == expv[g][x], "R4 read contents", v, expv[g][x]);
        sumexp[x] = 1'b0;
        do_read(sum_off(g), v);
        chk(v == sumexp, "R3 summary after clear", v, sumexp);
      end
      do_read(pend_off(g, 0), v);
      chk(v == 16'h0, "R4 cleared on read", v, 0);
      chk(irq_out[g] == 1'b0, "R5 irq drops when drained", irq_out[g], 0);
    end

    // R2: every bit position of one register
    for (int d = 0; d < 16; d++) begin
      do_write(pend_off(5, 2), 32'(d));
      do_read(sum_off(5), v);
      chk(v == 16'h0004, "R2 only index 2 flagged", v, 16'h0004);
    end
    do_read(pend_off(5, 2), v);
    chk(v == 16'hFFFF, "R2 all bits accumulated", v, 16'hFFFF);

    // R6: rejected writes
    do_write(pend_off(3, 1), 32'd16);
    chk(wr_err == 1'b1, "R6 err on value 16", wr_err, 1);
    @(negedge clk);
    chk(wr_err == 1'b0, "R6 err single cycle", wr_err, 0);
    do_write(pend_off(3, 1), 32'd31);
    chk(wr_err == 1'b1, "R6 err on value 31", wr_err, 1);
    do_write(pend_off(3, 1) | 24'h4, 32'd2);
    chk(wr_err == 1'b1, "R6 R1 err on unaligned offset", wr_err, 1);
    do_write(sum_off(3), 32'd2);
    chk(wr_err == 1'b1, "R6 err on summary offset", wr_err, 1);
    do_write(24'h900000, 32'd2);
    chk(wr_err == 1'b1, "R6 err beyond map", wr_err, 1);
    chk(irq_out == 16'h0, "R6 ignored writes raise nothing", irq_out, 0);
    do_read(pend_off(3, 1), v);
    chk(v == 16'h0, "R6 register untouched", v, 0);

    // R7: same-cycle write and read on one register
    do_write(pend_off(2, 1), 32'd9);
    wr_valid = 1'b1; wr_addr = pend_off(2, 1); wr_data = 32'd3;
    rd_valid = 1'b1; rd_addr = pend_off(2, 1);
    @(negedge clk);
    wr_valid = 1'b0; rd_valid = 1'b0;
    chk(rd_data == 16'h0200, "R7 read returns old", rd_data, 16'h0200);
    chk(irq_out[2] == 1'b1, "R7 irq stays", irq_out[2], 1);
    do_read(pend_off(2, 1), v);
    chk(v == 16'h0008, "R7 new bit kept", v, 16'h0008);

    // R9: undecoded reads
    do_write(pend_off(0, 0), 32'd1);
    do_read(pend_off(0, 0) | 24'h4, v);
    chk(v == 16'h0, "R9 unaligned read zero", v, 0);
    do_read(24'h900000, v);
    chk(v == 16'h0, "R9 out-of-map read zero", v, 0);
    chk(irq_out[0] == 1'b1, "R9 irq unaffected", irq_out[0], 1);
    do_read(pend_off(0, 0), v);
    chk(v == 16'h0002, "R9 no side effect", v, 16'h0002);

    // R8: reset in the middle of pending state
    do_write(pend_off(15, 7), 32'd15);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(irq_out == 16'h0, "R8 reset clears pending", irq_out, 0);
    do_read(pend_off(15, 7), v);
    chk(v == 16'h0, "R8 register zero after reset", v, 0);

    finish_run();
  end
endmodule